// File: doc/BRIEF.md
# USB Host Port Suspend and Resume Controller

This block holds the suspend and resume state of one downstream port of a USB host controller. Software reaches it through a small port register with three fields: an enable bit, a suspend bit and a force-resume bit. A single write strobe carries all three fields at once. The block also owns the port-change status flag that a remote wake raises. It combines that flag with an interrupt-enable input to drive an interrupt line.

Toward the port, the block watches four inputs: a transaction-busy flag, a frame-boundary strobe, a remote-wake detect and the controller-halted flag. From these it drives two outputs. One tells the line logic to send resume signalling. The other allows start-of-frame packets to go down the port.

A suspend request does not act at once. It waits for a frame boundary with no transaction in flight. A resume can start in two ways, from software or from a device wake, and the two differ in their status side effects. Software always ends a resume by clearing the force-resume bit. If the controller is halted when that happens, no frames flow on the port, and after a bounded idle time the port falls back into suspend.

Top module: `usb_port_suspend_ctl`

## Requirements
- R1: After reset, and after any register write with bit 0 (enable) at 0, the register reads enable=0, suspend=0 and force-resume=0, and the port is idle. After reset, pcd, irq, resume_sig and sof_en are also 0. A write with bit 0 at 1 sets enable. In the register, bit 0 is enable, bit 1 is suspend and bit 2 is force-resume.
- R2: A write with bit 1 at 1 starts a suspend only when enable already read 1 and the port is idle. Otherwise the suspend bit stays 0.
- R3: The suspend bit reads 1 from the cycle after an accepted suspend write. The port becomes suspended at the first frame strobe seen while txn_busy is 0. Until then it stays pending.
- R4: A write of bits 2 and 0 at 1 to a suspended port sets force-resume, and resume_sig is high in the next cycle. pcd does not change. The same write to a port that is not suspended is ignored.
- R5: While force-resume reads 1, a write with bit 2 at 0 ends the resume. For one cycle the register reads suspend=1 and force-resume=0, and after that both read 0.
- R6: A wake_det pulse on a suspended port sets force-resume and pcd in the next cycle. resume_sig rises exactly WAKE_DELAY cycles after force-resume rises.
- R7: pcd falls only in the cycle after a pcd_ack. If a wake and an acknowledge arrive in the same cycle, the wake wins and pcd stays 1.
- R8: irq is high exactly when pcd is 1 and pc_int_en is 1.
- R9: sof_en is high only when the port is enabled and idle (neither suspended nor resuming) and hc_halted is 0.
- R10: When a resume ends while hc_halted is 1, the port returns to suspended (suspend reads 1) RESUSPEND_CYCLES cycles after the bits clear, provided hc_halted stays 1 for that whole time. If hc_halted falls earlier, the port stays enabled.
- R11: wake_det has no effect on a port that is not suspended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Port register write strobe |
| wdata | input | 3 | Write data: bit 0 enable, bit 1 suspend, bit 2 force-resume |
| rd_data | output | 3 | Register read value, same field positions as wdata |
| pcd_ack | input | 1 | Software acknowledge that clears the port-change flag |
| pc_int_en | input | 1 | Port-change interrupt enable |
| pcd | output | 1 | Port-change-detect status flag |
| irq | output | 1 | Interrupt request |
| txn_busy | input | 1 | A transaction is in progress on the port |
| frame_strobe | input | 1 | One-cycle frame-boundary pulse |
| wake_det | input | 1 | Remote wake detected on the port |
| hc_halted | input | 1 | Host controller is halted |
| resume_sig | output | 1 | Drive resume signalling on the port |
| sof_en | output | 1 | Allow start-of-frame packets on the port |

## Verification
Two functions can fall in the same cycle on the pcd flag: a device wake on a suspended port sets it, and a software acknowledge clears it. The bench suspends the port and sets pcd with a first wake. It ends that resume, suspends again, and then raises wake_det and pcd_ack in the same cycle. In the following cycle it requires pcd to read 1 with force-resume set. A random phase then produces further coincidences, including a wake arriving together with a software force-resume write. A behavioural model checks all of them on every clock.

// File: rtl/usb_port_suspend_ctl.sv
module usb_port_suspend_ctl #(
  parameter int WAKE_DELAY       = 6,
  parameter int RESUSPEND_CYCLES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] wdata,
  output logic [2:0] rd_data,
  input  logic       pcd_ack,
  input  logic       pc_int_en,
  output logic       pcd,
  output logic       irq,
  input  logic       txn_busy,
  input  logic       frame_strobe,
  input  logic       wake_det,
  input  logic       hc_halted,
  output logic       resume_sig,
  output logic       sof_en
);

  localparam int WW = (WAKE_DELAY > 0) ? $clog2(WAKE_DELAY + 1) : 1;
  localparam int RW = (RESUSPEND_CYCLES > 1) ? $clog2(RESUSPEND_CYCLES) : 1;
  localparam logic [WW-1:0] WFULL = WW'(WAKE_DELAY);
  localparam logic [RW-1:0] RLAST = RW'(RESUSPEND_CYCLES - 1);

  typedef enum logic [2:0] {
    ENABLED, SUSP_PEND, SUSPENDED, RESUMING, RESUME_END
  } state_t;

  state_t        st;
  logic          en, arm;
  logic [WW-1:0] wcnt;
  logic [RW-1:0] rcnt;

  wire disable_wr = reg_wr & ~wdata[0];
  wire wake_hit   = wake_det & (st == SUSPENDED) & ~disable_wr;

  assign rd_data    = {st == RESUMING, st != ENABLED, en};
  assign resume_sig = (st == RESUMING) && (wcnt == WFULL);
  assign sof_en     = (st == ENABLED) && en && !hc_halted;
  assign irq        = pcd & pc_int_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ENABLED;
      en   <= 1'b0;
      pcd  <= 1'b0;
      arm  <= 1'b0;
      wcnt <= '0;
      rcnt <= '0;
    end else begin
      if (wake_hit)     pcd <= 1'b1;
      else if (pcd_ack) pcd <= 1'b0;

      if (disable_wr) begin
        en  <= 1'b0;
        st  <= ENABLED;
        arm <= 1'b0;
      end else begin
        case (st)
          ENABLED: begin
            if (reg_wr) en <= 1'b1;
            if (reg_wr && wdata[1] && en) begin
              st  <= SUSP_PEND;
              arm <= 1'b0;
            end else if (arm) begin
              if (!hc_halted) arm <= 1'b0;
              else if (rcnt == RLAST) begin
                st  <= SUSPENDED;
                arm <= 1'b0;
              end else rcnt <= rcnt + 1'b1;
            end
          end
          SUSP_PEND:
            if (frame_strobe && !txn_busy) st <= SUSPENDED;
          SUSPENDED:
            if (wake_det) begin
              st   <= RESUMING;
              wcnt <= '0;
            end else if (reg_wr && wdata[2]) begin
              st   <= RESUMING;
              wcnt <= WFULL;
            end
          RESUMING: begin
            if (wcnt != WFULL) wcnt <= wcnt + 1'b1;
            if (reg_wr && !wdata[2]) st <= RESUME_END;
          end
          RESUME_END: begin
            st   <= ENABLED;
            arm  <= hc_halted;
            rcnt <= '0;
          end
          default: st <= ENABLED;
        endcase
      end
    end
  end

  // R6
  resume_fpr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_sig |-> rd_data[2]);

  // R9
  sof_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_en |-> (!hc_halted && rd_data[1:0] == 2'b01));

  // R4
  sw_resume_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SUSPENDED && reg_wr && wdata == 3'b101 && !wake_det && !pcd)
      |=> (!pcd && rd_data[2]));

  // R6
  wake_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |=> (pcd && rd_data[2]));

  // R7
  pcd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pcd) |-> $past(pcd_ack));

  // R2
  susp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wdata[1] && !en && st == ENABLED) |=> (st == ENABLED));

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SUSP_PEND && (txn_busy || !frame_strobe) && !disable_wr)
      |=> (st == SUSP_PEND));

endmodule

// File: tb/usb_port_suspend_ctl_test.sv
module usb_port_suspend_ctl_test;
  localparam int WD = 6;
  localparam int RL = 12;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, pcd_ack = 0, pc_int_en = 0, txn_busy = 0;
  logic frame_strobe = 0, wake_det = 0, hc_halted = 0;
  logic [2:0] wdata = 0;
  logic [2:0] rd_data;
  logic pcd, irq, resume_sig, sof_en;

  usb_port_suspend_ctl #(.WAKE_DELAY(WD), .RESUSPEND_CYCLES(RL)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wdata(wdata), .rd_data(rd_data),
    .pcd_ack(pcd_ack), .pc_int_en(pc_int_en), .pcd(pcd), .irq(irq),
    .txn_busy(txn_busy), .frame_strobe(frame_strobe), .wake_det(wake_det),
    .hc_halted(hc_halted), .resume_sig(resume_sig), .sof_en(sof_en));

  always #10 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  // Behavioural reference: phase 0 idle, 1 pending, 2 suspended, 3 resuming, 4 ending
  int m_ph = 0, m_wait = 0, m_idle = 0;
  bit m_en = 0, m_pcd = 0, m_watch = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_en = 0; m_pcd = 0; m_watch = 0; m_wait = 0; m_idle = 0;
    end else begin
      bit off, woke;
      off  = reg_wr && !wdata[0];
      woke = wake_det && m_ph == 2 && !off;
      if (woke) m_pcd = 1;
      else if (pcd_ack) m_pcd = 0;
      if (off) begin
        m_en = 0; m_ph = 0; m_watch = 0;
      end else if (m_ph == 0) begin
        bit was_en;
        was_en = m_en;
        if (reg_wr) m_en = 1;
        if (reg_wr && wdata[1] && was_en) begin
          m_ph = 1; m_watch = 0;
        end else if (m_watch) begin
          if (!hc_halted) m_watch = 0;
          else begin
            m_idle++;
            if (m_idle >= RL) begin m_ph = 2; m_watch = 0; end
          end
        end
      end else if (m_ph == 1) begin
        if (frame_strobe && !txn_busy) m_ph = 2;
      end else if (m_ph == 2) begin
        if (wake_det) begin m_ph = 3; m_wait = 0; end
        else if (reg_wr && wdata[2]) begin m_ph = 3; m_wait = WD; end
      end else if (m_ph == 3) begin
        if (m_wait < WD) m_wait++;
        if (reg_wr && !wdata[2]) m_ph = 4;
      end else begin
        m_ph = 0; m_watch = hc_halted; m_idle = 0;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(rd_data, {m_ph == 3, m_ph != 0, m_en}, "R2 register bits vs model");
    chk(resume_sig, (m_ph == 3 && m_wait >= WD), "R6 resume_sig vs model");
    chk(sof_en, (m_ph == 0 && m_en && !hc_halted), "R9 sof_en vs model");
    chk(pcd, m_pcd, "R7 pcd vs model");
    chk(irq, (m_pcd && pc_int_en), "R8 irq vs model");
  end

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic wr(input logic [2:0] d);
    reg_wr = 1; wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic pulse_wake();
    wake_det = 1; @(negedge clk); wake_det = 0;
  endtask

  task automatic strobe();
    frame_strobe = 1; @(negedge clk); frame_strobe = 0;
  endtask

  task automatic go_suspended();
    wr(3'b011);
    strobe();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rd_data, 0, "R1 reset register");
    chk({pcd, irq, resume_sig, sof_en}, 0, "R1 reset outputs");

    // R2 suspend while disabled is ignored
    wr(3'b010);
    chk(rd_data, 0, "R2 suspend write while disabled");
    wr(3'b001);
    chk(rd_data, 3'b001, "R1 enable write");
    chk(sof_en, 1, "R9 sof on enabled port");
    hc_halted = 1; @(negedge clk);
    chk(sof_en, 0, "R9 sof off while halted");
    hc_halted = 0;

    // R4 force-resume on a non-suspended port ignored; R11 wake ignored
    wr(3'b101);
    chk(rd_data, 3'b001, "R4 force-resume ignored when not suspended");
    pulse_wake();
    chk({pcd, rd_data}, 4'b0001, "R11 wake on enabled port ignored");

    // R3 suspend held off by busy transaction
    wr(3'b011);
    chk(rd_data, 3'b011, "R3 suspend bit reads 1 after write");
    chk(sof_en, 0, "R9 no sof while pending");
    txn_busy = 1;
    strobe(); strobe();
    repeat (3) @(negedge clk);
    txn_busy = 0;
    @(negedge clk);
    wr(3'b101);
    chk(rd_data, 3'b011, "R3 still pending, resume write ignored");
    strobe();
    chk(rd_data, 3'b011, "R3 suspended after idle frame strobe");

    // R4 software resume
    wr(3'b101);
    chk(rd_data, 3'b111, "R4 force-resume set");
    chk(resume_sig, 1, "R4 resume signalling at once");
    chk(pcd, 0, "R4 software resume leaves pcd clear");
    repeat (4) @(negedge clk);
    // R5 end of resume
    wr(3'b001);
    chk(rd_data, 3'b011, "R5 ending cycle");
    @(negedge clk);
    chk(rd_data, 3'b001, "R5 both bits cleared");

    // R6/R8 wake with interrupt enabled
    pc_int_en = 1;
    go_suspended();
    pulse_wake();
    chk(rd_data, 3'b111, "R6 wake sets force-resume");
    chk(pcd, 1, "R6 wake sets pcd");
    chk(irq, 1, "R8 irq raised");
    chk(resume_sig, 0, "R6 signalling not yet");
    repeat (WD - 1) @(negedge clk);
    chk(resume_sig, 0, "R6 signalling one cycle early");
    @(negedge clk);
    chk(resume_sig, 1, "R6 signalling after WAKE_DELAY");
    repeat (5) @(negedge clk);
    chk(pcd, 1, "R7 pcd held without ack");
    pcd_ack = 1; @(negedge clk); pcd_ack = 0;
    chk({pcd, irq}, 0, "R7 ack clears pcd and irq");
    wr(3'b001); @(negedge clk);

    // R7 wake and ack in the same cycle
    go_suspended();
    pulse_wake();
    wr(3'b001); @(negedge clk);
    go_suspended();
    pcd_ack = 1; wake_det = 1; @(negedge clk);
    pcd_ack = 0; wake_det = 0;
    chk(pcd, 1, "R7 wake beats acknowledge");
    chk(rd_data, 3'b111, "R6 coincident wake resumes");
    pc_int_en = 0; @(negedge clk);
    chk(irq, 0, "R8 irq masked");
    pcd_ack = 1; @(negedge clk); pcd_ack = 0;

    // R10 resume ended while halted
    hc_halted = 1;
    wr(3'b001);
    @(negedge clk);
    chk(rd_data, 3'b001, "R10 bits cleared");
    chk(sof_en, 0, "R10 no sof while halted");
    repeat (RL - 1) @(negedge clk);
    chk(rd_data, 3'b001, "R10 still enabled one cycle early");
    @(negedge clk);
    chk(rd_data, 3'b011, "R10 fell back to suspend");
    chk(pcd, 0, "R10 no status change");

    // R10 halt released early keeps port enabled
    wr(3'b101);
    wr(3'b001);
    @(negedge clk);
    repeat (3) @(negedge clk);
    hc_halted = 0;
    repeat (RL + 2) @(negedge clk);
    chk(rd_data, 3'b001, "R10 stays enabled after halt released");

    // R1 disable from suspended
    go_suspended();
    wr(3'b000);
    chk(rd_data, 3'b000, "R1 disable clears suspend");

    // Random coincidences, checked by the model every cycle
    for (int i = 0; i < 600; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      reg_wr       = ($urandom % 5) == 0;
      wdata        = {r[2], r[1], r[5:3] != 0};
      wake_det     = ($urandom % 7) == 0;
      pcd_ack      = ($urandom % 9) == 0;
      frame_strobe = ($urandom % 4) == 0;
      txn_busy     = r[6];
      hc_halted    = ($urandom % 3) == 0;
      pc_int_en    = r[7];
      @(negedge clk);
    end
    reg_wr = 0; wake_det = 0; pcd_ack = 0; frame_strobe = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule